// File: doc/BRIEF.md
# SPI Master, Clock Mode 0, with Select Pulsing Between Words

This block is a serial peripheral master that moves words of 4 to 16 bits between a pair of FIFO-style word interfaces and a four-wire serial link. It pulls a word from the transmit side whenever it is enabled and a word is waiting. It shifts that word out most significant bit first and shifts the same number of bits in from the data input. It then hands the received word to the receive side with a one-cycle strobe. The serial clock idles low. The peripheral samples on the rising edge and new output data is launched on the falling edge.

Every word sits in its own low pulse of the active-low frame select. When a further word is waiting as one ends, the select goes high for one serial-clock period. The next word then repeats the full setup sequence: select falls, the first data bit appears half a period later, and the first rising clock edge follows after one more half period. The serial clock comes from the system clock through a programmable divider. The divider value is captured when a burst starts and the word length is captured with each word. The data output driver is enabled only while the select is low. The clock driver is enabled only when the block is strapped as master.

Top module: `spi_m0_master`

## Requirements
- R1: While no transfer is in progress, `sclk` is 0, `fss_n` is 1, `mosi_oe` is 0, `mosi` is 0 and `busy` is 0.
- R2: `sclk_oe` equals `master_mode` at all times.
- R3: A word is taken (`tx_pop` high for one cycle) only when `enable` and `tx_valid` are both high, and only from idle or at the end of an inter-word gap. `fss_n` falls in the next cycle with `mosi_oe` high.
- R4: Let H = `div_val`/2 rounded down, with 1 used when that is 0, sampled when a burst leaves idle. `mosi` is 0 for the first H cycles after `fss_n` falls and then shows the word's top bit. The first rising edge of `sclk` comes 2H cycles after the fall.
- R5: `sclk` is high for H cycles and low for H cycles per bit. Consecutive rising edges within a word are 2H cycles apart. `mosi` changes only while `sclk` falls or during the setup half period, never while `sclk` is high. The peripheral input is sampled at each rising edge.
- R6: A `word_len` value of k gives k+1 bits for k of 3 to 15; values 0 to 2 give 4 bits. The low bits of `tx_data` are sent most significant first, and higher bits of `tx_data` are ignored. Each word gives exactly that many rising edges.
- R7: `fss_n` returns high 2H cycles after the last rising `sclk` edge of a word.
- R8: If a word is waiting when a word ends, `fss_n` stays high for exactly 2H cycles and the next word then falls `fss_n` again with the full setup sequence.
- R9: `rx_valid` is a one-cycle pulse in the cycle right after the edge that captures the last bit. At that time `rx_data` holds the received bits right-justified, in arrival order with the first bit most significant, and zeros above.
- R10: `busy` is high from the cycle `fss_n` first falls until `fss_n` returns high with no word waiting. It stays high across inter-word gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Allows new words to be started |
| master_mode | input | 1 | Strap selecting master operation; drives the clock pad enable |
| div_val | input | DIV_W | System clocks per serial-clock period (even, 2 or more) |
| word_len | input | 4 | Word length code for the waiting word (bits minus one) |
| tx_valid | input | 1 | Transmit side holds a word |
| tx_data | input | DATA_W | Word to transmit, right-justified |
| tx_pop | output | 1 | Word accepted from transmit side this cycle |
| rx_valid | output | 1 | Received word ready (one-cycle strobe) |
| rx_data | output | DATA_W | Received word, right-justified, zero-extended |
| sclk | output | 1 | Serial clock |
| sclk_oe | output | 1 | Serial clock pad enable |
| fss_n | output | 1 | Active-low frame select |
| mosi | output | 1 | Serial data out |
| mosi_oe | output | 1 | Serial data out pad enable |
| miso | input | 1 | Serial data in |
| busy | output | 1 | Transfer or inter-word gap in progress |

## Verification
The main path is run with single words at every divider class: H of 1, 2, 3 and 4, a zero divider that must act as 2, and an odd divider that must round down. These separate a correct half-period count from off-by-one setup, hold and gap timing. Word lengths of 4, 8, 9, 12 and 16 bits and length codes below 3 tell a true MSB-first shift of the selected bits from a fixed-width shift or a missed clamp. Transmit patterns with ones above the chosen length show that upper bits are dropped. Receive patterns that differ in every position from the transmit word show that the two directions are not crossed. A three-word burst of mixed lengths exercises the select gap, the busy hold across gaps and the per-word length reload. A disabled start and a cleared master strap check the gating inputs.

// File: rtl/spi_m0_pkg.sv
package spi_m0_pkg;

    // Phases of one word and of the gap between words.
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,   // select low, data line still 0
        PH_LEAD,    // first bit on the line, clock still low
        PH_HIGH,    // clock high, input captured on entry
        PH_LOW,     // clock low, next bit launched on entry
        PH_TAIL,    // last bit held, clock low before select rises
        PH_GAP1,    // select high, first half of the gap
        PH_GAP2     // select high, second half of the gap
    } phase_e;

endpackage

// File: rtl/spi_m0_halftick.sv
module spi_m0_halftick #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [CNT_W-1:0] half,
    output logic             expire
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tick_t;

    tick_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (restart || (s_q.cnt == '0)) begin
            s_d.cnt = half - 1'b1;
        end else begin
            s_d.cnt = s_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign expire = (s_q.cnt == '0);

endmodule

// File: rtl/spi_m0_shreg.sv
module spi_m0_shreg #(
    parameter int DATA_W = 16,
    parameter int BIT_W  = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_word,
    input  logic [BIT_W-1:0]  load_bits,
    input  logic              shift,
    input  logic              capture,
    input  logic              sdi,
    output logic              sdo,
    output logic [DATA_W-1:0] rx_word
);

    typedef struct packed {
        logic [DATA_W-1:0] tx;
        logic [DATA_W-1:0] rx;
    } sh_t;

    sh_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load) begin
            // left-justify the selected low bits so the top bit leads
            s_d.tx = load_word << (BIT_W'(DATA_W) - load_bits);
            s_d.rx = '0;
        end else begin
            if (shift) begin
                s_d.tx = {s_q.tx[DATA_W-2:0], 1'b0};
            end
            if (capture) begin
                s_d.rx = {s_q.rx[DATA_W-2:0], sdi};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sdo     = s_q.tx[DATA_W-1];
    assign rx_word = s_q.rx;

endmodule

// File: rtl/spi_m0_master.sv
module spi_m0_master #(
    parameter int DATA_W = 16,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              master_mode,
    input  logic [DIV_W-1:0]  div_val,
    input  logic [$clog2(DATA_W)-1:0] word_len,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_pop,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    output logic              sclk,
    output logic              sclk_oe,
    output logic              fss_n,
    output logic              mosi,
    output logic              mosi_oe,
    input  logic              miso,
    output logic              busy
);
    import spi_m0_pkg::*;

    localparam int LEN_W    = $clog2(DATA_W);
    localparam int BIT_W    = $clog2(DATA_W + 1);
    localparam int CNT_W    = DIV_W - 1;
    localparam int MIN_BITS = 4;

    typedef struct packed {
        phase_e           phase;
        logic [BIT_W-1:0] left;   // bits still to capture
        logic [CNT_W-1:0] half;   // half period latched per burst
        logic             rxv;
    } ctl_t;

    ctl_t c_d, c_q;

    logic             expire;
    logic             restart;
    logic             pop;
    logic             do_shift;
    logic             do_cap;
    logic             sdo;
    logic             start_ok;
    logic [CNT_W-1:0] half_in;
    logic [CNT_W-1:0] half_use;
    logic [BIT_W-1:0] len_bits;

    // Half period from the divider: floor(div/2), never below one.
    always_comb begin
        half_in = CNT_W'(div_val >> 1);
        if (half_in == '0) begin
            half_in = CNT_W'(1);
        end
    end

    // Word length code to bit count, clamped at the minimum length.
    always_comb begin
        if (word_len < LEN_W'(MIN_BITS - 1)) begin
            len_bits = BIT_W'(MIN_BITS);
        end else begin
            len_bits = BIT_W'(word_len) + 1'b1;
        end
    end

    assign start_ok = enable && tx_valid;
    assign restart  = (c_q.phase == PH_IDLE);
    assign half_use = (c_q.phase == PH_IDLE) ? half_in : c_q.half;

    always_comb begin
        c_d      = c_q;
        c_d.rxv  = 1'b0;
        pop      = 1'b0;
        do_shift = 1'b0;
        do_cap   = 1'b0;
        unique case (c_q.phase)
            PH_IDLE: begin
                c_d.half = half_in;
                if (start_ok) begin
                    pop       = 1'b1;
                    c_d.left  = len_bits;
                    c_d.phase = PH_SETUP;
                end
            end
            PH_SETUP: begin
                if (expire) c_d.phase = PH_LEAD;
            end
            PH_LEAD: begin
                if (expire) begin
                    do_cap    = 1'b1;
                    c_d.phase = PH_HIGH;
                end
            end
            PH_HIGH: begin
                if (expire) begin
                    if (c_q.left == '0) begin
                        c_d.phase = PH_TAIL;
                    end else begin
                        do_shift  = 1'b1;
                        c_d.phase = PH_LOW;
                    end
                end
            end
            PH_LOW: begin
                if (expire) begin
                    do_cap    = 1'b1;
                    c_d.phase = PH_HIGH;
                end
            end
            PH_TAIL: begin
                if (expire) c_d.phase = start_ok ? PH_GAP1 : PH_IDLE;
            end
            PH_GAP1: begin
                if (expire) c_d.phase = PH_GAP2;
            end
            PH_GAP2: begin
                if (expire) begin
                    if (start_ok) begin
                        pop       = 1'b1;
                        c_d.left  = len_bits;
                        c_d.phase = PH_SETUP;
                    end else begin
                        c_d.phase = PH_IDLE;
                    end
                end
            end
            default: c_d.phase = PH_IDLE;
        endcase
        if (do_cap) begin
            c_d.left = c_q.left - 1'b1;
            c_d.rxv  = (c_q.left == BIT_W'(1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q       <= '0;
            c_q.phase <= PH_IDLE;
        end else begin
            c_q <= c_d;
        end
    end

    spi_m0_halftick #(
        .CNT_W (CNT_W)
    ) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .half    (half_use),
        .expire  (expire)
    );

    spi_m0_shreg #(
        .DATA_W (DATA_W),
        .BIT_W  (BIT_W)
    ) u_shreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (pop),
        .load_word (tx_data),
        .load_bits (len_bits),
        .shift     (do_shift),
        .capture   (do_cap),
        .sdi       (miso),
        .sdo       (sdo),
        .rx_word   (rx_data)
    );

    always_comb begin
        fss_n = (c_q.phase == PH_IDLE) || (c_q.phase == PH_GAP1) ||
                (c_q.phase == PH_GAP2);
        mosi  = ((c_q.phase == PH_LEAD) || (c_q.phase == PH_HIGH) ||
                 (c_q.phase == PH_LOW)  || (c_q.phase == PH_TAIL)) ? sdo : 1'b0;
    end

    assign sclk     = (c_q.phase == PH_HIGH);
    assign mosi_oe  = !fss_n;
    assign busy     = (c_q.phase != PH_IDLE);
    assign sclk_oe  = master_mode;
    assign tx_pop   = pop;
    assign rx_valid = c_q.rxv;

endmodule

// File: rtl/spi_m0_checker.sv
module spi_m0_checker (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic tx_valid,
    input logic tx_pop,
    input logic rx_valid,
    input logic sclk,
    input logic fss_n,
    input logic mosi,
    input logic mosi_oe,
    input logic busy
);

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!sclk && fss_n && !mosi_oe && !mosi));

    a_r3_pop_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> (tx_valid && enable));

    a_r3_frame_follows_pop: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |=> (!fss_n && mosi_oe && !sclk));

    a_r4_setup_line_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fss_n) |-> (!sclk && !mosi));

    a_r5_data_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> $stable(mosi));

    a_r5_clock_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> !fss_n);

    a_r8_gap_held: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(fss_n) && busy) |=> fss_n);

    a_r9_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    a_r10_busy_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !fss_n |-> busy);

endmodule

bind spi_m0_master spi_m0_checker u_chk (.*);

// File: tb/tb_spi_m0_master.sv
`timescale 1ns/1ps
module tb_spi_m0_master;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        enable;
    logic        master_mode;
    logic [7:0]  div_val;
    logic [3:0]  word_len;
    logic        tx_valid;
    logic [15:0] tx_data;
    logic        tx_pop;
    logic        rx_valid;
    logic [15:0] rx_data;
    logic        sclk, sclk_oe, fss_n, mosi, mosi_oe, busy;
    logic        miso;

    always #2 clk = ~clk;

    spi_m0_master dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .master_mode(master_mode),
        .div_val(div_val), .word_len(word_len), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_pop(tx_pop), .rx_valid(rx_valid),
        .rx_data(rx_data), .sclk(sclk), .sclk_oe(sclk_oe), .fss_n(fss_n),
        .mosi(mosi), .mosi_oe(mosi_oe), .miso(miso), .busy(busy)
    );

    // {len code[43:40], divider[39:32], tx word[31:16], peripheral word[15:0]}
    localparam logic [43:0] VEC [7] = '{
        {4'hF, 8'd2, 16'hA5C3, 16'h3C5A},
        {4'h3, 8'd2, 16'hFFF9, 16'h0006},
        {4'h7, 8'd4, 16'h00B2, 16'h004D},
        {4'hB, 8'd6, 16'h0F0F, 16'h0AC3},
        {4'hF, 8'd8, 16'hFFFF, 16'h0001},
        {4'h0, 8'd0, 16'h000A, 16'h0005},
        {4'h8, 8'd5, 16'h0155, 16'h01AA}
    };

    int total = 0;
    int bad = 0;
    bit reported = 0;

    logic [15:0] q_tx  [64];
    logic [15:0] q_rx  [64];
    logic [3:0]  q_len [64];
    int wr = 0;
    int rd = 0;
    int cur_h = 1;

    assign tx_valid = (rd < wr);
    assign tx_data  = q_tx[rd % 64];
    assign word_len = q_len[rd % 64];

    always @(posedge clk) if (tx_pop) rd <= rd + 1;

    function automatic int nbits(input logic [3:0] code);
        return (code < 4'd3) ? 4 : int'(code) + 1;
    endfunction

    function automatic int lowmask(input int n);
        return (1 << n) - 1;
    endfunction

    function automatic int half_of(input logic [7:0] d);
        return ((d >> 1) == 0) ? 1 : int'(d >> 1);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Monitor and peripheral model, sampled on the falling system edge.
    int cyc = 0, fidx = 0, ridx = 0, done = 0, cur = 0, cur_n = 4;
    int t_pop = 0, t_fall = 0, t_first = 0, t_last = 0, t_rise = 0, nrise = 0;
    bit prev_sclk = 0, prev_fss = 1, gap_pending = 0, pre_mosi = 0;
    logic [15:0] mon = '0, sh_s = '0;

    initial miso = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (tx_pop) t_pop = cyc;
            if (prev_fss && !fss_n) begin
                cur = fidx;
                fidx++;
                cur_n = nbits(q_len[cur]);
                if (gap_pending) chk("R8 select gap length", cyc - t_rise, 2 * cur_h);
                gap_pending = 0;
                chk("R3 pop to select fall", cyc - t_pop, 1);
                chk("R3 data pad enabled", int'(mosi_oe), 1);
                t_fall = cyc;
                nrise = 0;
                mon = '0;
                sh_s = q_rx[cur] << (16 - cur_n);
                miso = sh_s[15];
            end
            if (!fss_n && cyc == t_fall + cur_h - 1) pre_mosi = mosi;
            if (!fss_n && cyc == t_fall + cur_h)
                chk("R4 first bit after half period", {pre_mosi, mosi},
                    {1'b0, q_tx[cur][cur_n-1]});
            if (!prev_sclk && sclk) begin
                if (nrise == 0) t_first = cyc;
                mon = {mon[14:0], mosi};
                nrise++;
                t_last = cyc;
            end
            if (prev_sclk && !sclk) begin
                sh_s = sh_s << 1;
                miso = sh_s[15];
            end
            if (rx_valid) begin
                chk("R9 received word", int'(rx_data),
                    int'(q_rx[ridx]) & lowmask(nbits(q_len[ridx])));
                chk("R9 strobe after last capture", cyc - t_last, 0);
                ridx++;
            end
            if (!prev_fss && fss_n) begin
                t_rise = cyc;
                chk("R6 sent bits MSB first", int'(mon), int'(q_tx[cur]) & lowmask(cur_n));
                chk("R6 rising edge count", nrise, cur_n);
                chk("R4 first rising edge", t_first - t_fall, 2 * cur_h);
                chk("R5 bit period", t_last - t_first, (cur_n - 1) * 2 * cur_h);
                chk("R7 select hold after last bit", t_rise - t_last, 2 * cur_h);
                chk("R10 busy at select rise", int'(busy), (fidx < wr) ? 1 : 0);
                gap_pending = busy;
                done++;
            end
            prev_sclk = sclk;
            prev_fss  = fss_n;
        end
    end

    task automatic drain();
        wait (done == wr);
        repeat (4) @(negedge clk);
    endtask

    task automatic idle_check(input string when);
        chk({"R1 sclk low ", when}, int'(sclk), 0);
        chk({"R1 select high ", when}, int'(fss_n), 1);
        chk({"R1 data pad off ", when}, int'(mosi_oe), 0);
        chk({"R1 busy low ", when}, int'(busy), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", done, wr);
        report();
    end

    initial begin
        rst_n = 1'b0;
        enable = 1'b0;
        master_mode = 1'b1;
        div_val = 8'd2;
        repeat (3) @(negedge clk);
        idle_check("in reset");
        rst_n = 1'b1;
        @(negedge clk);
        idle_check("after reset");
        chk("R3 no pop when nothing waits", int'(tx_pop), 0);
        enable = 1'b1;

        // Single words from the vector table.
        for (int i = 0; i < 7; i++) begin
            @(negedge clk);
            div_val = VEC[i][39:32];
            cur_h = half_of(VEC[i][39:32]);
            q_len[wr] = VEC[i][43:40];
            q_tx[wr]  = VEC[i][31:16];
            q_rx[wr]  = VEC[i][15:0];
            wr++;
            drain();
            idle_check("after single word");
        end

        // Back-to-back burst of three words with differing lengths.
        @(negedge clk);
        div_val = 8'd4;
        cur_h = 2;
        q_len[wr]   = 4'hF; q_tx[wr]   = 16'h8001; q_rx[wr]   = 16'h7FFE;
        q_len[wr+1] = 4'h3; q_tx[wr+1] = 16'h000C; q_rx[wr+1] = 16'h0003;
        q_len[wr+2] = 4'h8; q_tx[wr+2] = 16'h0133; q_rx[wr+2] = 16'h00CC;
        wr += 3;
        drain();
        idle_check("after burst");

        // Disabled: a waiting word must not start.
        @(negedge clk);
        enable = 1'b0;
        div_val = 8'd2;
        cur_h = 1;
        q_len[wr] = 4'h5; q_tx[wr] = 16'h002D; q_rx[wr] = 16'h0012;
        wr++;
        repeat (40) @(negedge clk);
        chk("R3 no start while disabled select", int'(fss_n), 1);
        chk("R3 no start while disabled pops", rd, wr - 1);
        enable = 1'b1;
        drain();

        // Clock pad enable follows the master strap.
        chk("R2 clock pad on as master", int'(sclk_oe), 1);
        master_mode = 1'b0;
        @(negedge clk);
        chk("R2 clock pad off when not master", int'(sclk_oe), 0);
        master_mode = 1'b1;
        @(negedge clk);
        chk("R2 clock pad back on", int'(sclk_oe), 1);

        chk("R9 strobe count", ridx, wr);
        report();
    end

endmodule